// File: doc/BRIEF.md
# Sync-Gated Interval Timer Channel

This block is one channel of a general-purpose interval timer. It keeps a 16-bit up-counter that advances on a selected tick source: every system clock, a divided system clock, or a strobe from the video side such as a dot-clock or line strobe. The counter either wraps from 0xFFFF to 0 or, when asked to, returns to zero once it has reached a programmable limit. Either event can set a sticky flag and send a one-cycle interrupt request to an external interrupt controller. The request is sent once until the channel is re-armed, or on every event.

Software reaches three registers through a simple register bus: the count, a control word and the limit. The control word also reports three status bits. The two limit and wrap flags clear as a side effect of reading the control word. A blanking level input lets the channel pause, stop or restart in step with the display. Which behaviours are available depends on a `KIND` parameter. Kinds 0 and 1 are the display-synchronised channels. Kind 2 is the channel with the divide-by-8 source and the stop modes.

Top module: `tmr_channel`

## Requirements
- R1: After reset the count, the control word, the limit and `irq` are all zero.
- R2: With no sync and no source bit set, the count rises by one on every clock. When the count steps from 0xFFFF to 0, control bits 12 (wrap flag) and 10 (event flag) are set.
- R3: With control bit 3 set, the count goes to 0 on the tick after it equals the limit. When the count steps onto the limit, bits 11 (limit flag) and 10 are set.
- R4: Control bit 4 enables an interrupt on the limit event and bit 5 enables one on the wrap event. `irq` is high for one cycle, in the same cycle that the count shows the new value.
- R5: With control bit 6 clear, only the first enabled event after a control write raises `irq`. With bit 6 set, every enabled event raises it.
- R6: Reading the control word (`bus_sel`=1) returns its current value and then clears bits 11 and 12. Bit 10 is kept. Bits 15:13 always read 0.
- R7: Writing the control word stores bits 9:0, clears bits 12:10, sets the count to 0 and re-arms the one-shot interrupt.
- R8: Writing the limit (`bus_sel`=2) leaves the count unchanged. Writing the count (`bus_sel`=0) loads the written value.
- R9: On kinds 0/1, control bit 8 makes the count advance only on cycles with `ext_tick` high. On kind 2, bit 9 makes it advance once every 8 clocks, and the first tick comes 8 clocks after the control write.
- R10: On kind 2, with bit 0 set and sync mode (bits 2:1) 0 or 3, the count holds. Sync modes 1 and 2 let it run.
- R11: On kinds 0/1, with bit 0 set, sync modes 1 and 2 zero the count on a rising edge of `blank` and let it run otherwise. Sync mode 0 holds the count while `blank` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_sel | input | 2 | Register select: 0 count, 1 control, 2 limit |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the selected register (combinational) |
| ext_tick | input | 1 | External tick strobe (dot or line rate) |
| blank | input | 1 | Blanking level used by the sync modes |
| irq | output | 1 | One-cycle interrupt request |

## Verification
A register write takes effect on the clock edge that samples it, so the bench looks at the new state at the following falling edge. Each tick-driven update shows on the count and on `irq` on the same rising edge as the tick. The bench therefore samples one time unit after that edge, counting edges exactly when it checks divide-by-8 and free-running values. A `blank` rising edge zeroes the count on the first clock that sees it. A control read shows the flags before the clear, and the cleared value is confirmed with a second read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CFG_W = 10;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_TARGET = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // Count is held by the sync configuration this cycle.
  function automatic logic sync_hold(input int kind, input logic [CFG_W-1:0] cfg,
                                     input logic blank_lvl);
    logic [1:0] sm;
    sm = cfg[2:1];
    if (!cfg[0]) return 1'b0;
    if (kind == 2) return (sm == 2'd0) || (sm == 2'd3);
    return (sm == 2'd0) && blank_lvl;
  endfunction

  // Count is zeroed by a blanking edge this cycle.
  function automatic logic sync_zero(input int kind, input logic [CFG_W-1:0] cfg,
                                     input logic blank_rise);
    logic [1:0] sm;
    sm = cfg[2:1];
    return (kind != 2) && cfg[0] && ((sm == 2'd1) || (sm == 2'd2)) && blank_rise;
  endfunction

  // Readback of the control word: flags above the stored configuration.
  function automatic logic [15:0] mode_word(input logic [CFG_W-1:0] cfg, input logic ev,
                                            input logic tgt, input logic wrp);
    return {3'b000, wrp, tgt, ev, cfg};
  endfunction

  // Interrupt gating: enabled event, and repeat mode or not yet fired.
  function automatic logic irq_allowed(input logic [CFG_W-1:0] cfg, input logic hit_t,
                                       input logic hit_w, input logic fired);
    return ((hit_t && cfg[4]) || (hit_w && cfg[5])) && (cfg[6] || !fired);
  endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int KIND     = 0,
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic sel_alt,
  input  logic sel_div,
  input  logic ext_tick,
  output logic tick
);
  logic [DIV_LOG2-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  generate
    if (KIND == 2) begin : g_div
      assign tick = sel_div ? (&pre_q) : 1'b1;
      logic unused_alt;
      assign unused_alt = sel_alt ^ ext_tick;
    end else begin : g_ext
      assign tick = sel_alt ? ext_tick : 1'b1;
      logic unused_div;
      assign unused_div = sel_div ^ (&pre_q);
    end
  endgenerate
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hold,
  input  logic             zero,
  input  logic             load_en,
  input  logic [REG_W-1:0] load_val,
  input  logic [REG_W-1:0] target,
  input  logic             to_target,
  output logic [REG_W-1:0] count,
  output logic             hit_target,
  output logic             hit_wrap
);
  logic [REG_W-1:0] count_q, nxt;
  logic adv, back_to_zero;

  always_comb begin
    adv          = tick && !hold && !zero && !load_en;
    back_to_zero = to_target && (count_q == target);
    nxt          = count_q + 1'b1;
    hit_target   = adv && !back_to_zero && (nxt == target);
    hit_wrap     = adv && !back_to_zero && (&count_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (zero)    count_q <= '0;
    else if (load_en) count_q <= load_val;
    else if (adv)     count_q <= back_to_zero ? '0 : nxt;
  end

  assign count = count_q;
endmodule

// File: rtl/tmr_status.sv
module tmr_status
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [CFG_W-1:0] wcfg,
  input  logic             mode_rd,
  input  logic             hit_target,
  input  logic             hit_wrap,
  output logic [CFG_W-1:0] cfg,
  output logic             ev_flag,
  output logic             tgt_flag,
  output logic             wrap_flag,
  output logic             irq
);
  logic fired_q, fire;

  assign fire = irq_allowed(cfg, hit_target, hit_wrap, fired_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; ev_flag <= 1'b0; tgt_flag <= 1'b0; wrap_flag <= 1'b0;
      fired_q <= 1'b0; irq <= 1'b0;
    end else if (mode_wr) begin
      cfg <= wcfg; ev_flag <= 1'b0; tgt_flag <= 1'b0; wrap_flag <= 1'b0;
      fired_q <= 1'b0; irq <= 1'b0;
    end else begin
      ev_flag   <= ev_flag | hit_target | hit_wrap;
      tgt_flag  <= (tgt_flag & !mode_rd) | hit_target;
      wrap_flag <= (wrap_flag & !mode_rd) | hit_wrap;
      fired_q   <= fired_q | fire;
      irq       <= fire;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int KIND     = 0,
  parameter int REG_W    = 16,
  parameter int DIV_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_sel,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             ext_tick,
  input  logic             blank,
  output logic             irq
);
  reg_sel_e         sel;
  logic             mode_wr, mode_rd, cnt_wr, tgt_wr;
  logic [REG_W-1:0] target_q, count;
  logic [CFG_W-1:0] cfg;
  logic             ev_flag, tgt_flag, wrap_flag;
  logic             blank_q, blank_rise, tick, hold, zero;
  logic             hit_target, hit_wrap;
  logic [15:0]      mode_view;

  assign sel     = reg_sel_e'(bus_sel);
  assign mode_wr = bus_wr && (sel == SEL_MODE);
  assign cnt_wr  = bus_wr && (sel == SEL_COUNT);
  assign tgt_wr  = bus_wr && (sel == SEL_TARGET);
  assign mode_rd = bus_rd && (sel == SEL_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
      blank_q  <= 1'b0;
    end else begin
      if (tgt_wr) target_q <= bus_wdata;
      blank_q <= blank;
    end
  end

  assign blank_rise = blank && !blank_q;
  assign hold       = sync_hold(KIND, cfg, blank);
  assign zero       = mode_wr || sync_zero(KIND, cfg, blank_rise);

  tmr_tick_gen #(.KIND(KIND), .DIV_LOG2(DIV_LOG2)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(mode_wr), .sel_alt(cfg[8]),
    .sel_div(cfg[9]), .ext_tick(ext_tick), .tick(tick)
  );

  tmr_counter #(.REG_W(REG_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold(hold), .zero(zero),
    .load_en(cnt_wr), .load_val(bus_wdata), .target(target_q), .to_target(cfg[3]),
    .count(count), .hit_target(hit_target), .hit_wrap(hit_wrap)
  );

  tmr_status u_stat (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .wcfg(bus_wdata[CFG_W-1:0]),
    .mode_rd(mode_rd), .hit_target(hit_target), .hit_wrap(hit_wrap), .cfg(cfg),
    .ev_flag(ev_flag), .tgt_flag(tgt_flag), .wrap_flag(wrap_flag), .irq(irq)
  );

  assign mode_view = mode_word(cfg, ev_flag, tgt_flag, wrap_flag);

  always_comb begin
    unique case (sel)
      SEL_COUNT:  bus_rdata = count;
      SEL_MODE:   bus_rdata = REG_W'(mode_view);
      SEL_TARGET: bus_rdata = target_q;
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int KIND  = 0,
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             mode_wr,
  input logic             mode_rd,
  input logic [9:0]       wcfg,
  input logic [REG_W-1:0] count,
  input logic [15:0]      mode_view,
  input logic             hit_target,
  input logic             hit_wrap,
  input logic             irq
);
  logic irq_src, stop_now;
  assign irq_src  = (hit_target && mode_view[4]) || (hit_wrap && mode_view[5]);
  assign stop_now = (KIND == 2) && mode_view[0] &&
                    ((mode_view[2:1] == 2'd0) || (mode_view[2:1] == 2'd3));

  a_r2_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
    hit_wrap |=> (mode_view[12] && mode_view[10]));

  a_r3_limit_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hit_target |=> (mode_view[11] && mode_view[10]));

  a_r4_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(irq_src));

  a_r5_one_shot_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !mode_view[6]) |=> !irq);

  a_r6_high_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mode_view[15:13] == 3'b000);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rd && !hit_target && !hit_wrap && !mode_wr) |=> (mode_view[12:11] == 2'b00));

  a_r7_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (count == '0 && mode_view[12:10] == 3'b000 && mode_view[9:0] == $past(wcfg)));

  a_r10_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_now && !bus_wr) |=> (count == $past(count)));
endmodule

bind tmr_channel tmr_channel_chk #(.KIND(KIND), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .mode_wr(mode_wr), .mode_rd(mode_rd),
  .wcfg(bus_wdata[9:0]), .count(count), .mode_view(mode_view),
  .hit_target(hit_target), .hit_wrap(hit_wrap), .irq(irq)
);

// File: tb/tmr_channel_test.sv
module tmr_channel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_sel = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] rdata, rdata2;
  logic        ext_tick = 1'b0, blank = 1'b0;
  logic        irq, irq2;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  localparam logic [1:0] S_CNT = 2'd0, S_MODE = 2'd1, S_TGT = 2'd2;

  always #5 clk = ~clk;

  tmr_channel #(.KIND(0)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(rdata), .ext_tick(ext_tick), .blank(blank), .irq(irq)
  );

  tmr_channel #(.KIND(2)) uut_c2 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(rdata2), .ext_tick(ext_tick), .blank(blank), .irq(irq2)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] s, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_sel = s; #1 d = rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] s, output logic [15:0] d, output logic [15:0] d2);
    bus_sel = s; #1 d = rdata; d2 = rdata2;
  endtask

  task automatic pulse;
    @(negedge clk); ext_tick = 1'b1;
    @(posedge clk); #1 ext_tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] a, b;
    peek(S_CNT, a, b);  chk("R1 count", a, 16'h0);
    peek(S_MODE, a, b); chk("R1 mode", a, 16'h0);
    peek(S_TGT, a, b);  chk("R1 limit", a, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_freerun;
    logic [15:0] a, b;
    bus_write(S_TGT, 16'h8000);
    bus_write(S_MODE, 16'h0020);
    bus_read(S_CNT, a); chk("R2 one per clock", a, 16'h0001);
    bus_write(S_CNT, 16'hFFFE);
    @(posedge clk); #1 peek(S_CNT, a, b);
    chk("R2 count ffff", a, 16'hFFFF); chk("R4 no irq yet", {15'b0, irq}, 16'h0);
    @(posedge clk); #1 peek(S_CNT, a, b);
    chk("R2 wrap to 0", a, 16'h0000); chk("R4 irq on wrap", {15'b0, irq}, 16'h1);
    @(posedge clk); #1 peek(S_CNT, a, b);
    chk("R4 irq one cycle", {15'b0, irq}, 16'h0);
    bus_read(S_MODE, a); chk("R2 wrap and event flags", a, 16'h1420);
    bus_read(S_MODE, a); chk("R6 read clears flags", a, 16'h0420);
  endtask

  task automatic t_limit;
    logic [15:0] a, b;
    bus_write(S_TGT, 16'd3);
    bus_write(S_MODE, 16'h0118);
    for (int i = 1; i <= 8; i++) begin
      pulse; peek(S_CNT, a, b);
      chk("R3 limit count", a, 16'(i % 4));
      chk("R5 one-shot irq", {15'b0, irq}, {15'b0, (i == 3)});
    end
    bus_read(S_MODE, a); chk("R3 limit flags", a, 16'h0D18);
    bus_read(S_MODE, a); chk("R6 event flag kept", a, 16'h0518);
    bus_write(S_MODE, 16'h0158);
    bus_read(S_MODE, a); chk("R7 write clears flags", a, 16'h0158);
    repeat (5) @(posedge clk);
    #1 peek(S_CNT, a, b); chk("R9 no strobe no count", a, 16'h0);
    for (int i = 1; i <= 8; i++) begin
      pulse; peek(S_CNT, a, b);
      chk("R5 repeat irq", {15'b0, irq}, {15'b0, (i == 3 || i == 7)});
    end
  endtask

  task automatic t_keep;
    logic [15:0] a, b;
    pulse; pulse;
    bus_write(S_TGT, 16'd10);
    peek(S_CNT, a, b); chk("R8 limit write keeps count", a, 16'd2);
    pulse; peek(S_CNT, a, b); chk("R8 counts past old limit", a, 16'd3);
    bus_write(S_CNT, 16'd9);
    peek(S_CNT, a, b); chk("R8 count load", a, 16'd9);
    pulse; peek(S_CNT, a, b);
    chk("R3 reaches new limit", a, 16'd10); chk("R4 irq on limit", {15'b0, irq}, 16'h1);
    pulse; peek(S_CNT, a, b); chk("R3 back to zero", a, 16'd0);
    bus_write(S_MODE, 16'hFFFF);
    bus_read(S_MODE, a); chk("R6 high bits read zero", a, 16'h03FF);
  endtask

  task automatic t_blank;
    logic [15:0] a, b;
    blank = 1'b0;
    bus_write(S_MODE, 16'h0103);
    pulse; pulse; pulse;
    peek(S_CNT, a, b); chk("R11 counts before blank", a, 16'd3);
    @(negedge clk); blank = 1'b1;
    @(posedge clk); #1 peek(S_CNT, a, b); chk("R11 zero on blank edge", a, 16'd0);
    pulse; peek(S_CNT, a, b); chk("R11 runs in blank", a, 16'd1);
    @(negedge clk); blank = 1'b0;
    bus_write(S_MODE, 16'h0105);
    pulse; pulse;
    @(negedge clk); blank = 1'b1;
    @(posedge clk); #1 peek(S_CNT, a, b); chk("R11 mode 2 zero on edge", a, 16'd0);
    @(negedge clk); blank = 1'b0;
    bus_write(S_MODE, 16'h0101);
    @(negedge clk); blank = 1'b1;
    pulse; peek(S_CNT, a, b); chk("R11 pause in blank", a, 16'd0);
    @(negedge clk); blank = 1'b0;
    pulse; peek(S_CNT, a, b); chk("R11 resume after blank", a, 16'd1);
  endtask

  task automatic t_div8;
    logic [15:0] a, b;
    bus_write(S_MODE, 16'h0200);
    repeat (7) @(posedge clk);
    #1 peek(S_CNT, a, b); chk("R9 div8 not yet", b, 16'd0);
    @(posedge clk); #1 peek(S_CNT, a, b); chk("R9 div8 first tick", b, 16'd1);
    repeat (8) @(posedge clk);
    #1 peek(S_CNT, a, b); chk("R9 div8 second tick", b, 16'd2);
  endtask

  task automatic t_stop;
    logic [15:0] a, b;
    bus_write(S_MODE, 16'h0001);
    repeat (20) @(posedge clk);
    #1 peek(S_CNT, a, b);
    chk("R10 mode 0 stops", b, 16'd0); chk("R11 mode 0 no blank runs", a, 16'd20);
    bus_write(S_MODE, 16'h0007);
    repeat (20) @(posedge clk);
    #1 peek(S_CNT, a, b); chk("R10 mode 3 stops", b, 16'd0);
    bus_write(S_MODE, 16'h0003);
    repeat (5) @(posedge clk);
    #1 peek(S_CNT, a, b); chk("R10 mode 1 runs", b, 16'd5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_reset;
    t_freerun;
    t_limit;
    t_keep;
    t_blank;
    t_div8;
    t_stop;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule